// File: doc/BRIEF.md
# Cross-Clock Doorbell Interrupt Unit

This block joins two processor buses that run on unrelated clocks and lets side B ring side A. Side B writes a word to one of four transmit registers. The word arrives in the matching receive register on side A and sets that channel's pending flag there. If side A has enabled the channel, a level interrupt is raised toward side A. Side A reads the receive register to collect the word, and that read acknowledges the doorbell. Software normally writes the channel index as the word, so the handler can tell which doorbell fired.

Each write on side B flips a per-channel toggle. Side A passes the toggle through a synchronizer chain and turns each change into a one-cycle set request. A read on side A is a local clear request. When a set and a clear meet in the same cycle, the set takes priority, so no doorbell is lost.

A build parameter picks one of two register layouts. The layouts differ in their register offsets and in the bit positions of the per-channel flags and enables.

Top module: `mu_doorbell`

## Requirements
- R1: After reset, all pending flags, enables and received words are zero. `irq_a` is low, and the status and control registers read as zero.
- R2: A side-B write to transmit address TX_BASE+4*n (n = 0..3) delivers the written word to receive register n and sets pending flag n. This happens no later than the fourth rising `clk_a` edge after the `clk_b` edge that took the write.
- R3: A side-A read of RX_BASE+4*n returns the word held in receive register n in the same cycle, and clears pending flag n at that clock edge.
- R4: `irq_a` is high exactly while at least one channel has both its pending flag and its enable set. It stays high until a read or a control write changes that.
- R5: If a set request and a read-clear reach the same channel in the same `clk_a` cycle, the flag ends up set.
- R6: With LAYOUT_V2=0, the flag and the enable of channel n both sit at bit 24+(3-n). With LAYOUT_V2=1, both sit at bit n.
- R7: With LAYOUT_V2=0, the offsets are: transmit 0x000, receive 0x010, status 0x020, control 0x024. With LAYOUT_V2=1, they are: transmit 0x200, receive 0x280, status 0x12C, control 0x128. A write on side B to any non-transmit address is ignored.
- R8: Writes to the status register have no effect on the flags. Control bits other than the four enables read back as zero.
- R9: Reading the status or control register does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| a_addr | input | ADDR_W | Side A register address |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe; a read of a receive register clears its flag |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from `a_addr` |
| irq_a | output | 1 | Level interrupt toward side A, active high |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| b_addr | input | ADDR_W | Side B register address |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data (doorbell word) |

## Verification
Each failure mode in this block shows up at the ports within a few side-A cycles:

- A toggle that is lost or doubled in the crossing leaves the status register and `irq_a` out of step with the number of doorbells rung. This is visible four `clk_a` cycles after the side-B write.
- A clear that wins over a simultaneous set drops a doorbell for good. The bench sweeps the read across the arrival window to catch it.
- A wrong bit-position map for the selected layout reads back as a status or control word with the bit in the wrong place. It also leaves `irq_a` unmoved after enabling a pending channel.

// File: rtl/mu_doorbell.sv
module mu_doorbell #(
  parameter bit LAYOUT_V2   = 1'b0,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [31:0]       a_wdata,
  output logic [31:0]       a_rdata,
  output logic              irq_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic [31:0]       b_wdata
);
  localparam int NCH = 4;
  localparam logic [ADDR_W-1:0] TX_BASE = LAYOUT_V2 ? ADDR_W'(32'h200) : ADDR_W'(32'h000);
  localparam logic [ADDR_W-1:0] RX_BASE = LAYOUT_V2 ? ADDR_W'(32'h280) : ADDR_W'(32'h010);
  localparam logic [ADDR_W-1:0] ST_ADDR = LAYOUT_V2 ? ADDR_W'(32'h12C) : ADDR_W'(32'h020);
  localparam logic [ADDR_W-1:0] CT_ADDR = LAYOUT_V2 ? ADDR_W'(32'h128) : ADDR_W'(32'h024);

  function automatic int bitpos(input int ch);
    return LAYOUT_V2 ? ch : 24 + (NCH - 1 - ch);
  endfunction

  // side B: latch word, flip toggle
  logic [NCH-1:0] b_hit, tx_tog;
  logic [31:0]    tx_word [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_bhit
    assign b_hit[ch] = b_wr && (b_addr == TX_BASE + ADDR_W'(4 * ch));
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) begin
      tx_tog <= '0;
      for (int ch = 0; ch < NCH; ch++) tx_word[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (b_hit[ch]) begin
          tx_word[ch] <= b_wdata;
          tx_tog[ch]  <= ~tx_tog[ch];
        end
      end
    end
  end

  // side A: synchronize toggles, hold flags
  logic [NCH-1:0] sync_q [SYNC_STAGES];
  logic [NCH-1:0] sync_last, set_p, clr_p, flag_q, en_q;
  logic [31:0]    rx_word [NCH];
  logic           ct_wr;

  assign set_p = sync_q[SYNC_STAGES-1] ^ sync_last;
  assign ct_wr = a_wr && (a_addr == CT_ADDR);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_clr
    assign clr_p[ch] = a_rd && (a_addr == RX_BASE + ADDR_W'(4 * ch));
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      sync_last <= '0;
      flag_q    <= '0;
      en_q      <= '0;
      for (int ch = 0; ch < NCH; ch++) rx_word[ch] <= '0;
    end else begin
      sync_q[0] <= tx_tog;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      sync_last <= sync_q[SYNC_STAGES-1];
      flag_q    <= set_p | (flag_q & ~clr_p);
      for (int ch = 0; ch < NCH; ch++) begin
        if (set_p[ch]) rx_word[ch] <= tx_word[ch];
        if (ct_wr)     en_q[ch]    <= a_wdata[bitpos(ch)];
      end
    end
  end

  logic [31:0] flag_word, en_word;
  always_comb begin
    flag_word = '0;
    en_word   = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      flag_word[bitpos(ch)] = flag_q[ch];
      en_word[bitpos(ch)]   = en_q[ch];
    end
  end

  always_comb begin
    a_rdata = '0;
    if (a_addr == ST_ADDR) a_rdata = flag_word;
    if (a_addr == CT_ADDR) a_rdata = en_word;
    for (int ch = 0; ch < NCH; ch++)
      if (a_addr == RX_BASE + ADDR_W'(4 * ch)) a_rdata = rx_word[ch];
  end

  assign irq_a = |(flag_q & en_q);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    p_set_wins_r5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      set_p[ch] |=> flag_q[ch]);
    p_read_clears_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (clr_p[ch] && !set_p[ch]) |=> !flag_q[ch]);
    p_flag_holds_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (!set_p[ch] && !clr_p[ch]) |=> $stable(flag_q[ch]));
  end

  p_en_holds_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !ct_wr |=> $stable(en_q));
  p_irq_persists_r4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (irq_a && !a_rd && !a_wr) |=> irq_a);
endmodule

// File: tb/mu_doorbell_tb_top.sv
module mu_doorbell_tb_top;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam logic [11:0] IDLE = 12'hFFF;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic [11:0] a_addr = IDLE, b_addr = IDLE;
  logic a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] rdata_l, rdata_n;
  logic irq_l, irq_n;

  int checks = 0, errors = 0;
  logic [3:0]  m_flag [2];
  logic [3:0]  m_en   [2];
  logic [31:0] m_word [2][4];

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  mu_doorbell #(.LAYOUT_V2(1'b0)) dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd),
    .a_wdata(a_wdata), .a_rdata(rdata_l), .irq_a(irq_l),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_addr(b_addr), .b_wr(b_wr), .b_wdata(b_wdata));

  mu_doorbell #(.LAYOUT_V2(1'b1)) dut_n_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd),
    .a_wdata(a_wdata), .a_rdata(rdata_n), .irq_a(irq_n),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_addr(b_addr), .b_wr(b_wr), .b_wdata(b_wdata));

  function automatic int f_pos(input int v, input int n);
    return (v != 0) ? n : 27 - n;
  endfunction
  function automatic logic [11:0] f_tx(input int v, input int n);
    return ((v != 0) ? 12'h200 : 12'h000) + 12'(4 * n);
  endfunction
  function automatic logic [11:0] f_rx(input int v, input int n);
    return ((v != 0) ? 12'h280 : 12'h010) + 12'(4 * n);
  endfunction
  function automatic logic [11:0] f_st(input int v);
    return (v != 0) ? 12'h12C : 12'h020;
  endfunction
  function automatic logic [11:0] f_ct(input int v);
    return (v != 0) ? 12'h128 : 12'h024;
  endfunction
  function automatic logic [31:0] f_word(input int v, input logic [3:0] bits);
    logic [31:0] w = '0;
    for (int n = 0; n < 4; n++) w[f_pos(v, n)] = bits[n];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic a_read(input logic [11:0] addr, output logic [31:0] dl, output logic [31:0] dn);
    @(negedge clk_a);
    a_addr = addr; a_rd = 1'b1;
    #1 dl = rdata_l; dn = rdata_n;
    @(negedge clk_a);
    a_rd = 1'b0; a_addr = IDLE;
  endtask

  task automatic a_write(input logic [11:0] addr, input logic [31:0] d);
    @(negedge clk_a);
    a_addr = addr; a_wdata = d; a_wr = 1'b1;
    @(negedge clk_a);
    a_wr = 1'b0; a_addr = IDLE;
  endtask

  task automatic b_write(input logic [11:0] addr, input logic [31:0] d);
    @(negedge clk_b);
    b_addr = addr; b_wdata = d; b_wr = 1'b1;
    @(negedge clk_b);
    b_wr = 1'b0; b_addr = IDLE;
    repeat (6) @(negedge clk_a);
  endtask

  task automatic doorbell(input int v, input int n, input logic [31:0] d);
    b_write(f_tx(v, n), d);
    m_flag[v][n] = 1'b1;
    m_word[v][n] = d;
  endtask

  task automatic ack(input int v, input int n, input string tag);
    logic [31:0] dl, dn;
    a_read(f_rx(v, n), dl, dn);
    chk(tag, (v != 0) ? dn : dl, m_word[v][n]);
    m_flag[v][n] = 1'b0;
  endtask

  task automatic set_ctrl(input int v, input logic [31:0] d);
    a_write(f_ct(v), d);
    for (int n = 0; n < 4; n++) m_en[v][n] = d[f_pos(v, n)];
  endtask

  task automatic chk_state(input string tag);
    logic [31:0] dl, dn;
    for (int v = 0; v < 2; v++) begin
      a_read(f_st(v), dl, dn);
      chk({tag, " status"}, (v != 0) ? dn : dl, f_word(v, m_flag[v]));
      a_read(f_ct(v), dl, dn);
      chk({tag, " control"}, (v != 0) ? dn : dl, f_word(v, m_en[v]));
    end
    #1;
    chk({tag, " R4 irq legacy"}, {31'b0, irq_l}, {31'b0, |(m_flag[0] & m_en[0])});
    chk({tag, " R4 irq newer"}, {31'b0, irq_n}, {31'b0, |(m_flag[1] & m_en[1])});
  endtask

  initial begin
    #(CLK_A_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] dl, dn;
    logic irq_pre;
    void'($urandom(32'd20221012));
    for (int v = 0; v < 2; v++) begin
      m_flag[v] = '0; m_en[v] = '0;
      for (int n = 0; n < 4; n++) m_word[v][n] = '0;
    end
    repeat (4) @(negedge clk_a);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (2) @(negedge clk_a);

    // R1 reset state
    #1;
    chk("R1 irq legacy", {31'b0, irq_l}, 32'h0);
    chk("R1 irq newer", {31'b0, irq_n}, 32'h0);
    chk_state("R1");
    a_read(f_rx(0, 3), dl, dn);
    chk("R1 rx word", dl, 32'h0);

    // R2 R6 R4 legacy: masked doorbell then enable
    doorbell(0, 2, 32'd2);
    chk_state("R2 R6 legacy masked");
    set_ctrl(0, 32'h1 << 25);
    chk_state("R4 R6 legacy enabled");
    chk("R4 irq up", {31'b0, irq_l}, 32'h1);
    // R9 status read again leaves flag
    chk_state("R9 reread");
    ack(0, 2, "R3 legacy word");
    chk_state("R3 legacy cleared");

    // R6 R7 newer layout
    doorbell(1, 0, 32'd0);
    doorbell(1, 3, 32'd3);
    set_ctrl(1, 32'h8);
    chk_state("R6 R7 newer");
    ack(1, 3, "R3 newer word");
    chk_state("R3 newer cleared");

    // R8 status write ignored, control reserved bits
    a_write(f_st(1), 32'hFFFF_FFFF);
    a_write(f_st(0), 32'h0);
    chk_state("R8 status write");
    set_ctrl(0, 32'hFFFF_FFFF);
    a_read(f_ct(0), dl, dn);
    chk("R8 legacy ctrl reserved", dl, 32'h0F00_0000);
    set_ctrl(1, 32'hFFFF_FFFF);
    a_read(f_ct(1), dl, dn);
    chk("R8 newer ctrl reserved", dn, 32'h0000_000F);

    // R7 writes to non-transmit addresses on side B ignored
    b_write(12'h010, 32'hDEAD_BEEF);
    b_write(12'h280, 32'hDEAD_BEEF);
    b_write(12'h024, 32'hDEAD_BEEF);
    chk_state("R7 stray side-B writes");
    ack(1, 0, "R3 newer ch0 word");

    // R5 sweep the read across the arrival window
    set_ctrl(0, 32'h1 << 26);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_b);
      b_addr = f_tx(0, 1); b_wdata = 32'h100 + 32'(k); b_wr = 1'b1;
      @(negedge clk_b);
      b_wr = 1'b0; b_addr = IDLE;
      repeat (k) @(negedge clk_a);
      @(negedge clk_a);
      a_addr = f_rx(0, 1); a_rd = 1'b1;
      #1 irq_pre = irq_l;
      @(negedge clk_a);
      a_rd = 1'b0; a_addr = IDLE;
      repeat (6) @(negedge clk_a);
      m_word[0][1] = 32'h100 + 32'(k);
      m_flag[0][1] = !irq_pre;
      chk_state("R5 collision sweep");
      if (m_flag[0][1]) ack(0, 1, "R5 word kept");
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      int v, n, op;
      v = int'($urandom % 2); n = int'($urandom % 4); op = int'($urandom % 4);
      case (op)
        0, 1: doorbell(v, n, $urandom);
        2: ack(v, n, "R3 random word");
        default: set_ctrl(v, $urandom);
      endcase
      #1;
      chk("R4 random irq legacy", {31'b0, irq_l}, {31'b0, |(m_flag[0] & m_en[0])});
      chk("R4 random irq newer", {31'b0, irq_n}, {31'b0, |(m_flag[1] & m_en[1])});
      if (i % 10 == 9) chk_state("R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule